// File: doc/BRIEF.md
# Sum-of-Products Output Cell

This block is one configurable output cell of a sum-of-products logic array. A vector of product-term results from the AND plane is ORed into a single sum term. That sum either drives the pin directly or is captured by a D flip-flop on the rising clock edge. A final stage sets the pin polarity. A dedicated product term controls the pin's output enable. Two shared control terms act on the flip-flop: an asynchronous clear and a clock-synchronous preset.

The cell also returns a true/complement feedback pair to the AND plane. In registered mode the feedback is the flip-flop's inverted output. In combinatorial mode it is the level on the pin, so a combinatorial cell whose enable is off acts as an input. The pin is modelled as a driven value, a driver enable and a sampled input, with no tri-state element inside the block. The two configuration bits are static settings, held constant in use.

Top module: `sop_out_cell`

## Requirements
- R1: With cfgComb=1 and cfgPolarity=1, pinOut equals the OR of all bits of prodTerms, with no clock edge involved.
- R2: cfgPolarity=1 drives the selected value to pinOut unchanged (active high). cfgPolarity=0 drives its inverse (active low). This applies in both modes.
- R3: With cfgComb=0 (registered), pinOut changes only at a rising clk edge. After the edge it shows the OR of prodTerms sampled at that edge, passed through the polarity stage.
- R4: pinOe equals oeTerm in both modes and does not depend on prodTerms.
- R5: While arstTerm=1, the flip-flop holds 0 without waiting for a clock edge. In registered mode pinOut is therefore !cfgPolarity.
- R6: spTerm=1 at a rising clk edge (with arstTerm=0) sets the flip-flop to 1. In registered mode pinOut is then cfgPolarity, whatever prodTerms holds.
- R7: When arstTerm and spTerm are both 1, the clear takes priority and the flip-flop stays 0.
- R8: In registered mode fbTrue is the flip-flop's inverted output and fbComp is its true output. pinIn has no effect on either.
- R9: In combinatorial mode fbTrue equals pinIn and fbComp equals !pinIn. With pinOe low, the pin therefore serves as an input to the array.
- R10: NUM_TERMS may be 8, 10, 12, 14 or 16. Every bit position, from index 0 up to NUM_TERMS-1, contributes to the sum term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Flip-flop clock, rising edge |
| arstTerm | input | 1 | Asynchronous clear product term, active high |
| spTerm | input | 1 | Synchronous preset product term, active high |
| cfgPolarity | input | 1 | 1 = active high, 0 = active low |
| cfgComb | input | 1 | 1 = combinatorial, 0 = registered |
| prodTerms | input | NUM_TERMS | Logic product-term results |
| oeTerm | input | 1 | Output-enable product term |
| pinIn | input | 1 | Level sampled on the pin |
| pinOut | output | 1 | Value driven onto the pin |
| pinOe | output | 1 | Pin driver enable |
| fbTrue | output | 1 | Feedback to the array, true sense |
| fbComp | output | 1 | Feedback to the array, complement sense |

## Verification
The assertions assume that any asynchronous clear pulse is still high at the next rising clock edge. The registered-data property does not account for a clear that comes and goes entirely between two edges. The properties also read the configuration bits at the same edge as the outputs, so changes to those bits are only ever made away from the clock edge. The directed stimulus changes every input half a cycle away from the rising edge. It keeps each clear pulse high across at least one edge, including the pulse that is raised mid-cycle to show the immediate clear.

// File: rtl/sop_cell_pkg.sv
package sop_cell_pkg;

  typedef struct packed {
    logic regMode;     // pin and feedback come from the flip-flop
    logic invertOut;   // active-low polarity selected
    logic presetLoad;  // synchronous preset requested this cycle
    logic driveEn;     // pin driver enable
  } cellStrobes_t;

endpackage

// File: rtl/sop_cell_ctrl.sv
module sop_cell_ctrl
  import sop_cell_pkg::*;
(
  input  logic         cfgPolarity,
  input  logic         cfgComb,
  input  logic         spTerm,
  input  logic         oeTerm,
  output cellStrobes_t strobes
);

  always_comb begin
    strobes            = '0;
    strobes.regMode    = ~cfgComb;
    strobes.invertOut  = ~cfgPolarity;
    strobes.presetLoad = spTerm;
    strobes.driveEn    = oeTerm;
  end

endmodule

// File: rtl/sop_cell_dp.sv
module sop_cell_dp
  import sop_cell_pkg::*;
#(
  parameter int NUM_TERMS = 16
) (
  input  logic                 clk,
  input  logic                 arstTerm,
  input  logic [NUM_TERMS-1:0] prodTerms,
  input  logic                 pinIn,
  input  cellStrobes_t         strobes,
  output logic                 pinOut,
  output logic                 fbTrue,
  output logic                 fbComp
);

  localparam int PAIRS = NUM_TERMS / 2;

  logic [PAIRS-1:0] pairOr;
  logic             sumTerm;
  logic             qReg;
  logic             selVal;

  // First OR level in pairs, then reduce the pair results
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign pairOr[p] = prodTerms[2*p] | prodTerms[2*p+1];
  end
  assign sumTerm = |pairOr;

  // Clear is asynchronous and outranks the clocked preset
  always_ff @(posedge clk or posedge arstTerm) begin
    if (arstTerm)                qReg <= 1'b0;
    else if (strobes.presetLoad) qReg <= 1'b1;
    else                         qReg <= sumTerm;
  end

  assign selVal = strobes.regMode ? qReg : sumTerm;
  assign pinOut = selVal ^ strobes.invertOut;

  // Registered: feed back the inverted flip-flop output; otherwise the pin
  always_comb begin
    if (strobes.regMode) begin
      fbTrue = ~qReg;
      fbComp = qReg;
    end else begin
      fbTrue = pinIn;
      fbComp = ~pinIn;
    end
  end

endmodule

// File: rtl/sop_out_cell.sv
module sop_out_cell
  import sop_cell_pkg::*;
#(
  parameter int NUM_TERMS = 16
) (
  input  logic                 clk,
  input  logic                 arstTerm,
  input  logic                 spTerm,
  input  logic                 cfgPolarity,
  input  logic                 cfgComb,
  input  logic [NUM_TERMS-1:0] prodTerms,
  input  logic                 oeTerm,
  input  logic                 pinIn,
  output logic                 pinOut,
  output logic                 pinOe,
  output logic                 fbTrue,
  output logic                 fbComp
);

  cellStrobes_t strobes;

  sop_cell_ctrl u_ctrl (
    .cfgPolarity (cfgPolarity),
    .cfgComb     (cfgComb),
    .spTerm      (spTerm),
    .oeTerm      (oeTerm),
    .strobes     (strobes)
  );

  sop_cell_dp #(.NUM_TERMS(NUM_TERMS)) u_dp (
    .clk       (clk),
    .arstTerm  (arstTerm),
    .prodTerms (prodTerms),
    .pinIn     (pinIn),
    .strobes   (strobes),
    .pinOut    (pinOut),
    .fbTrue    (fbTrue),
    .fbComp    (fbComp)
  );

  assign pinOe = strobes.driveEn;

endmodule

// File: rtl/sop_out_cell_chk.sv
module sop_out_cell_chk #(
  parameter int NUM_TERMS = 16
) (
  input logic                 clk,
  input logic                 arstTerm,
  input logic                 spTerm,
  input logic                 cfgPolarity,
  input logic                 cfgComb,
  input logic [NUM_TERMS-1:0] prodTerms,
  input logic                 oeTerm,
  input logic                 pinIn,
  input logic                 pinOut,
  input logic                 pinOe,
  input logic                 fbTrue,
  input logic                 fbComp
);

  // R1
  comb_sum_chk: assert property (@(posedge clk) disable iff (arstTerm)
    cfgComb |-> (pinOut == ((|prodTerms) ^ !cfgPolarity)));

  // R3
  reg_capture_chk: assert property (@(posedge clk) disable iff (arstTerm)
    (!spTerm && !cfgComb) |=>
      (cfgComb || pinOut == ($past(|prodTerms) ^ !cfgPolarity)));

  // R4
  oe_follow_chk: assert property (@(posedge clk) pinOe == oeTerm);

  // R5
  clear_pin_chk: assert property (@(posedge clk)
    (arstTerm && !cfgComb) |-> (pinOut == !cfgPolarity));

  // R6
  preset_pin_chk: assert property (@(posedge clk) disable iff (arstTerm)
    (spTerm && !cfgComb) |=> (cfgComb || pinOut == cfgPolarity));

  // R7
  clear_wins_chk: assert property (@(posedge clk)
    (arstTerm && spTerm && !cfgComb) |-> (pinOut == !cfgPolarity));

  // R8
  reg_fb_chk: assert property (@(posedge clk)
    !cfgComb |-> (fbComp == !fbTrue && fbTrue == !(pinOut ^ !cfgPolarity)));

  // R9
  comb_fb_chk: assert property (@(posedge clk)
    cfgComb |-> (fbTrue == pinIn && fbComp == !pinIn));

endmodule

bind sop_out_cell sop_out_cell_chk #(.NUM_TERMS(NUM_TERMS)) u_chk (
  .clk         (clk),
  .arstTerm    (arstTerm),
  .spTerm      (spTerm),
  .cfgPolarity (cfgPolarity),
  .cfgComb     (cfgComb),
  .prodTerms   (prodTerms),
  .oeTerm      (oeTerm),
  .pinIn       (pinIn),
  .pinOut      (pinOut),
  .pinOe       (pinOe),
  .fbTrue      (fbTrue),
  .fbComp      (fbComp)
);

// File: tb/test_sop_out_cell.sv
`timescale 1ns/1ps
module test_sop_out_cell;

  localparam int N = 16;

  logic         clk = 1'b0;
  logic         arstTerm = 1'b1;
  logic         spTerm = 1'b0;
  logic         cfgPolarity = 1'b1;
  logic         cfgComb = 1'b0;
  logic [N-1:0] prodTerms = '0;
  logic         oeTerm = 1'b0;
  logic         pinIn = 1'b0;
  logic         pinOut, pinOe, fbTrue, fbComp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sop_out_cell #(.NUM_TERMS(N)) i_sop_out_cell (
    .clk(clk), .arstTerm(arstTerm), .spTerm(spTerm),
    .cfgPolarity(cfgPolarity), .cfgComb(cfgComb), .prodTerms(prodTerms),
    .oeTerm(oeTerm), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .fbTrue(fbTrue), .fbComp(fbComp)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive inputs away from the rising edge; sample 1 ns after it.
  task automatic atNeg(); @(negedge clk); endtask
  task automatic afterEdge(); @(posedge clk); #1; endtask

  task automatic t_reset();
    atNeg(); cfgComb = 1'b0; cfgPolarity = 1'b1; #0.5;
    chk("R5 clear, active high", pinOut, 1'b0);
    chk("R4 oe low", pinOe, 1'b0);
    cfgPolarity = 1'b0; #0.5;
    chk("R5 clear, active low", pinOut, 1'b1);
    atNeg(); arstTerm = 1'b0; cfgPolarity = 1'b1;
  endtask

  task automatic t_comb();
    atNeg(); cfgComb = 1'b1; cfgPolarity = 1'b1; prodTerms = '0; #0.5;
    chk("R1 all zero", pinOut, 1'b0);
    prodTerms = 16'h0001; #0.5;
    chk("R10 lowest term", pinOut, 1'b1);
    prodTerms = 16'h8000; #0.5;
    chk("R10 highest term", pinOut, 1'b1);
    prodTerms = 16'h0400; #0.5;
    chk("R1 single middle term", pinOut, 1'b1);
    prodTerms = 16'h5A5A; #0.5;
    chk("R1 many terms", pinOut, 1'b1);
    cfgPolarity = 1'b0; prodTerms = '0; #0.5;
    chk("R2 comb active low, zero sum", pinOut, 1'b1);
    prodTerms = 16'h0020; #0.5;
    chk("R2 comb active low, one sum", pinOut, 1'b0);
  endtask

  task automatic t_registered();
    atNeg(); cfgComb = 1'b0; cfgPolarity = 1'b1; prodTerms = '0;
    afterEdge();
    chk("R3 captured zero", pinOut, 1'b0);
    atNeg(); prodTerms = 16'h0008; #0.5;
    chk("R3 no change before edge", pinOut, 1'b0);
    afterEdge();
    chk("R3 captured one", pinOut, 1'b1);
    atNeg(); prodTerms = '0; #0.5;
    chk("R3 holds until edge", pinOut, 1'b1);
    afterEdge();
    chk("R3 captured zero again", pinOut, 1'b0);
    atNeg(); cfgPolarity = 1'b0; #0.5;
    chk("R2 registered active low", pinOut, 1'b1);
    atNeg(); cfgPolarity = 1'b1;
  endtask

  task automatic t_preset();
    atNeg(); cfgComb = 1'b0; cfgPolarity = 1'b1; prodTerms = '0; spTerm = 1'b1;
    afterEdge();
    chk("R6 preset active high", pinOut, 1'b1);
    atNeg(); cfgPolarity = 1'b0; #0.5;
    chk("R6 preset active low", pinOut, 1'b0);
    atNeg(); spTerm = 1'b0; cfgPolarity = 1'b1;
    afterEdge();
    chk("R6 preset released", pinOut, 1'b0);
  endtask

  task automatic t_clear();
    atNeg(); cfgComb = 1'b0; cfgPolarity = 1'b1; prodTerms = 16'h0100;
    afterEdge();
    chk("R3 load one before clear", pinOut, 1'b1);
    atNeg(); #0.5; arstTerm = 1'b1; #0.3;
    chk("R5 immediate clear mid-cycle", pinOut, 1'b0);
    atNeg(); spTerm = 1'b1;
    afterEdge();
    chk("R7 clear beats preset", pinOut, 1'b0);
    atNeg(); arstTerm = 1'b0; spTerm = 1'b0; prodTerms = '0;
    afterEdge();
  endtask

  task automatic t_oe();
    atNeg(); oeTerm = 1'b1; prodTerms = 16'hFFFF; #0.5;
    chk("R4 oe high", pinOe, 1'b1);
    oeTerm = 1'b0; #0.5;
    chk("R4 oe low with terms set", pinOe, 1'b0);
    cfgComb = 1'b1; oeTerm = 1'b1; prodTerms = '0; #0.5;
    chk("R4 oe high comb mode", pinOe, 1'b1);
    atNeg(); oeTerm = 1'b0; cfgComb = 1'b0;
  endtask

  task automatic t_feedback();
    atNeg(); cfgComb = 1'b0; cfgPolarity = 1'b0; prodTerms = 16'h0002;
    afterEdge();
    chk("R8 fbTrue is inverted Q", fbTrue, 1'b0);
    chk("R8 fbComp is Q", fbComp, 1'b1);
    atNeg(); pinIn = 1'b1; #0.5;
    chk("R8 pinIn ignored (true)", fbTrue, 1'b0);
    chk("R8 pinIn ignored (comp)", fbComp, 1'b1);
    pinIn = 1'b0; #0.5;
    chk("R8 pinIn low ignored", fbTrue, 1'b0);
    atNeg(); cfgComb = 1'b1; oeTerm = 1'b0; pinIn = 1'b1; #0.5;
    chk("R9 comb fbTrue follows pin", fbTrue, 1'b1);
    chk("R9 comb fbComp inverse", fbComp, 1'b0);
    pinIn = 1'b0; #0.5;
    chk("R9 comb fbTrue low", fbTrue, 1'b0);
    chk("R9 comb fbComp high", fbComp, 1'b1);
  endtask

  initial begin
    t_reset();
    t_comb();
    t_registered();
    t_preset();
    t_clear();
    t_oe();
    t_feedback();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule